// File: doc/BRIEF.md
# Oscillator Frequency Word Selector with Holdover Memory

This block chooses the frequency control word fed to a digitally controlled oscillator. While the loop is tracking a reference, the word follows each new loop-filter sample. When the loop loses its reference, the block switches to a frozen word. That word is the mean of a band of older history samples, so a disturbance in the samples just before the loss does not affect it. In free-running operation, the block outputs a fixed center word. The oscillator then rests on the accuracy of the master clock alone.

An external controller chooses the operating mode through a 2-bit select. In the tracking code, an automatic-holdover request from reference-loss logic moves the block into holdover without a change of the select. The history is a circular store that holds one entry per loop-filter strobe, with one strobe nominally each millisecond. The store keeps a running sum over the band of sample ages from `NEAR_AGE` up to `FAR_AGE-1`, where age 0 is the newest sample. The holdover word is that sum divided by the band length and rounded down. Both outputs are registered.

Top module: `dco_hold_mem`

## Requirements
- R1: While `rst` is high, `dco_word` equals `CENTER` and `mode_out` equals 2'b10 (free).
- R2: `mode_out` shows the effective mode one cycle after the inputs. The codes are 00 tracking, 01 holdover, 10 free. Select 00 with `auto_hold` low gives tracking. Select 01 gives holdover. Selects 10 and 11 give free.
- R3: In tracking mode, a cycle with `lf_valid` high loads `lf_word` into `dco_word` on the next cycle. A cycle without the strobe leaves `dco_word` unchanged.
- R4: A strobe is written into the history only when the effective mode in that cycle is tracking. Strobes in holdover or free mode do not change a later holdover word.
- R5: On the cycle after holdover is entered (effective mode holdover while `mode_out` is not 01), `dco_word` becomes the floor of the mean of the recorded samples at ages `NEAR_AGE` to `FAR_AGE-1`. This requires at least `FAR_AGE` recorded samples since reset. Age 0 is the newest sample.
- R6: If holdover is entered with fewer than `FAR_AGE` recorded samples, `dco_word` becomes `CENTER`.
- R7: While holdover continues, `dco_word` stays constant whatever `lf_valid` and `lf_word` do.
- R8: Select 00 with `auto_hold` high behaves exactly as select 01.
- R9: In free mode, including the reserved select 11, `dco_word` is `CENTER` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode select from the controller |
| auto_hold | input | 1 | Reference-loss request; forces holdover under select 00 |
| lf_valid | input | 1 | Loop-filter sample strobe |
| lf_word | input | WORD_W | Loop-filter frequency word |
| dco_word | output | WORD_W | Frequency control word for the oscillator |
| mode_out | output | 2 | Effective mode, registered |

## Verification
The assertions assume that `mode_sel` and `auto_hold` are clean, synchronous levels. They also assume that `lf_word` is treated as meaningful only in a cycle where `lf_valid` is high. The bench drives every input from one task, a full cycle ahead of the edge that samples it, so no glitch or mid-cycle change reaches the block. The random part holds each mode for runs of many cycles and covers all four select codes and both levels of the request. The directed part fills the history past `FAR_AGE` entries, then places a burst of extreme samples at the recent ages so that a holdover entry shows they were left out.

// File: rtl/dco_hold_pkg.sv
package dco_hold_pkg;

    typedef enum logic [1:0] {
        MODE_TRACK = 2'b00,
        MODE_HOLD  = 2'b01,
        MODE_FREE  = 2'b10
    } dco_mode_e;

    typedef struct packed {
        logic record;  // write the strobe into history
        logic entry;   // first cycle of holdover
    } mode_evt_t;

    function automatic dco_mode_e decode_mode(input logic [1:0] sel, input logic auto_req);
        dco_mode_e m;
        case (sel)
            2'b00:   m = auto_req ? MODE_HOLD : MODE_TRACK;
            2'b01:   m = MODE_HOLD;
            default: m = MODE_FREE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dco_mode_ctrl.sv
module dco_mode_ctrl
    import dco_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       auto_hold,
    input  logic       lf_valid,
    output dco_mode_e  mode_now,
    output dco_mode_e  mode_q,
    output mode_evt_t  evt
);
    always_comb begin
        mode_now   = decode_mode(mode_sel, auto_hold);
        evt.record = (mode_now == MODE_TRACK) && lf_valid;
        evt.entry  = (mode_now == MODE_HOLD) && (mode_q != MODE_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_FREE;
        else     mode_q <= mode_now;
    end
endmodule

// File: rtl/dco_hist_store.sv
module dco_hist_store #(
    parameter int WORD_W   = 24,
    parameter int NEAR_AGE = 26,
    parameter int FAR_AGE  = 52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] band_mean,
    output logic              band_ready
);
    localparam int BAND_LEN = FAR_AGE - NEAR_AGE;
    localparam int PTR_W    = $clog2(FAR_AGE);
    localparam int CNT_W    = $clog2(FAR_AGE + 1);
    localparam int SUM_W    = WORD_W + $clog2(BAND_LEN + 1);
    localparam logic [PTR_W:0] DEPTH_X = (PTR_W+1)'(FAR_AGE);
    localparam logic [PTR_W:0] OFFS_X  = (PTR_W+1)'(FAR_AGE - NEAR_AGE);
    localparam logic [SUM_W-1:0] BAND_DIV = SUM_W'(BAND_LEN);

    logic [WORD_W-1:0] mem [FAR_AGE];
    logic [PTR_W-1:0]  wp;
    logic [CNT_W-1:0]  fill;
    logic [SUM_W-1:0]  band_sum;
    logic [PTR_W:0]    enter_x;
    logic [PTR_W-1:0]  enter_idx;
    logic [SUM_W-1:0]  quot;

    // Slot holding the sample about to move from age NEAR_AGE-1 to NEAR_AGE.
    always_comb begin
        enter_x = {1'b0, wp} + OFFS_X;
        if (enter_x >= DEPTH_X) enter_x = enter_x - DEPTH_X;
        enter_idx = enter_x[PTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FAR_AGE; i++) mem[i] <= '0;
            wp       <= '0;
            fill     <= '0;
            band_sum <= '0;
        end else if (wr_en) begin
            mem[wp]  <= wr_word;
            band_sum <= band_sum + SUM_W'(mem[enter_idx]) - SUM_W'(mem[wp]);
            wp       <= (wp == PTR_W'(FAR_AGE - 1)) ? '0 : wp + 1'b1;
            if (fill != CNT_W'(FAR_AGE)) fill <= fill + 1'b1;
        end
    end

    always_comb begin
        quot       = band_sum / BAND_DIV;
        band_mean  = quot[WORD_W-1:0];
        band_ready = (fill == CNT_W'(FAR_AGE));
    end
endmodule

// File: rtl/dco_word_sel.sv
module dco_word_sel
    import dco_hold_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter logic [WORD_W-1:0] CENTER = {1'b1, {(WORD_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  dco_mode_e         mode_now,
    input  mode_evt_t         evt,
    input  logic              lf_valid,
    input  logic [WORD_W-1:0] lf_word,
    input  logic [WORD_W-1:0] band_mean,
    input  logic              band_ready,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = word_q;
        case (mode_now)
            MODE_TRACK: if (lf_valid) word_d = lf_word;
            MODE_HOLD:  if (evt.entry) word_d = band_ready ? band_mean : CENTER;
            default:    word_d = CENTER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= CENTER;
        else     word_q <= word_d;
    end
endmodule

// File: rtl/dco_hold_mem.sv
module dco_hold_mem
    import dco_hold_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int NEAR_AGE = 26,
    parameter int FAR_AGE  = 52,
    parameter logic [WORD_W-1:0] CENTER = {1'b1, {(WORD_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              auto_hold,
    input  logic              lf_valid,
    input  logic [WORD_W-1:0] lf_word,
    output logic [WORD_W-1:0] dco_word,
    output logic [1:0]        mode_out
);
    dco_mode_e         mode_now, mode_q;
    mode_evt_t         evt;
    logic [WORD_W-1:0] band_mean;
    logic              band_ready;

    dco_mode_ctrl u_ctrl (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .auto_hold(auto_hold),
        .lf_valid(lf_valid), .mode_now(mode_now), .mode_q(mode_q), .evt(evt)
    );

    dco_hist_store #(.WORD_W(WORD_W), .NEAR_AGE(NEAR_AGE), .FAR_AGE(FAR_AGE)) u_hist (
        .clk(clk), .rst(rst), .wr_en(evt.record), .wr_word(lf_word),
        .band_mean(band_mean), .band_ready(band_ready)
    );

    dco_word_sel #(.WORD_W(WORD_W), .CENTER(CENTER)) u_sel (
        .clk(clk), .rst(rst), .mode_now(mode_now), .evt(evt), .lf_valid(lf_valid),
        .lf_word(lf_word), .band_mean(band_mean), .band_ready(band_ready),
        .word_q(dco_word)
    );

    assign mode_out = mode_q;
endmodule

// File: rtl/dco_hold_mem_chk.sv
module dco_hold_mem_chk #(
    parameter int WORD_W = 24,
    parameter logic [WORD_W-1:0] CENTER = {1'b1, {(WORD_W-1){1'b0}}}
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_sel,
    input logic              auto_hold,
    input logic              lf_valid,
    input logic [WORD_W-1:0] lf_word,
    input logic [WORD_W-1:0] dco_word,
    input logic [1:0]        mode_out
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (dco_word == CENTER && mode_out == 2'b10));

    p_hold_code_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01) |=> (mode_out == 2'b01));

    p_free_code_r2: assert property (@(posedge clk) disable iff (rst)
        mode_sel[1] |=> (mode_out == 2'b10));

    p_track_load_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && !auto_hold && lf_valid) |=> (dco_word == $past(lf_word)));

    p_hold_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && mode_out == 2'b01) |=> $stable(dco_word));

    p_auto_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && auto_hold) |=> (mode_out == 2'b01));

    p_free_center_r9: assert property (@(posedge clk) disable iff (rst)
        mode_sel[1] |=> (dco_word == CENTER));
endmodule

bind dco_hold_mem dco_hold_mem_chk #(.WORD_W(WORD_W), .CENTER(CENTER)) u_chk (.*);

// File: tb/dco_hold_mem_bench.sv
module dco_hold_mem_bench;
    localparam int W    = 24;
    localparam int NEAR = 26;
    localparam int FAR  = 52;
    localparam logic [W-1:0] CTR = 24'h800000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_sel = 2'b10;
    logic auto_hold = 1'b0;
    logic lf_valid = 1'b0;
    logic [W-1:0] lf_word = '0;
    logic [W-1:0] dco_word;
    logic [1:0] mode_out;

    int n_run = 0;
    int n_fail = 0;

    logic [W-1:0] mh [FAR];
    int mcnt = 0;
    logic [W-1:0] exp_word = CTR;
    logic [1:0] exp_mode = 2'b10;

    always #4 clk = ~clk;

    dco_hold_mem u_dco_hold_mem (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .auto_hold(auto_hold),
        .lf_valid(lf_valid), .lf_word(lf_word), .dco_word(dco_word), .mode_out(mode_out)
    );

    function automatic logic [1:0] eff_mode(input logic [1:0] s, input logic a);
        if (s == 2'b00) return a ? 2'b01 : 2'b00;
        if (s == 2'b01) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [W-1:0] band_avg();
        longint s = 0;
        for (int i = NEAR; i < FAR; i++) s += longint'(mh[i]);
        return W'(s / (FAR - NEAR));
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic a, input logic v, input logic [W-1:0] w);
        logic [1:0] e;
        string tag;
        mode_sel = s; auto_hold = a; lf_valid = v; lf_word = w;
        @(posedge clk);
        #1;
        e = eff_mode(s, a);
        case (e)
            2'b00: begin
                tag = "R3 track";
                if (v) begin
                    exp_word = w;
                    for (int i = FAR - 1; i > 0; i--) mh[i] = mh[i-1];
                    mh[0] = w;
                    if (mcnt < FAR) mcnt++;
                end
            end
            2'b01: begin
                if (exp_mode != 2'b01) begin
                    tag = (mcnt >= FAR) ? "R5 hold entry" : "R6 early hold";
                    exp_word = (mcnt >= FAR) ? band_avg() : CTR;
                end else tag = "R7 hold steady";
            end
            default: begin
                tag = (s == 2'b11) ? "R9 reserved" : "R9 free";
                exp_word = CTR;
            end
        endcase
        exp_mode = e;
        check(tag, dco_word, exp_word);
        check((s == 2'b00 && a) ? "R8 auto mode" : "R2 mode", W'(mode_out), W'(exp_mode));
    endtask

    initial begin
        logic [W-1:0] saved;
        logic [1:0] rs;
        logic ra;
        void'($urandom(32'd7321));
        for (int i = 0; i < FAR; i++) mh[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset word", dco_word, CTR);
        check("R1 reset mode", W'(mode_out), W'(2'b10));
        rst = 1'b0;

        // early holdover with little history
        for (int i = 0; i < 10; i++) step(2'b00, 1'b0, 1'b1, CTR + W'(i * 3));
        step(2'b01, 1'b0, 1'b0, '0);
        for (int i = 0; i < 5; i++) step(2'b01, 1'b0, 1'b1, W'($urandom));
        step(2'b00, 1'b0, 1'b0, '0);

        // fill history, then a burst of extreme recent samples
        for (int i = 0; i < 60; i++) step(2'b00, 1'b0, 1'b1, CTR + W'(i * 37));
        for (int i = 0; i < NEAR; i++) step(2'b00, 1'b0, 1'b1, 24'hFFFFFF);
        step(2'b00, 1'b1, 1'b1, 24'h000001);
        saved = dco_word;
        for (int i = 0; i < 4; i++) step(2'b00, 1'b1, 1'b1, 24'h123456);

        // strobes in free mode must not enter history
        for (int i = 0; i < 8; i++) step(2'b10, 1'b0, 1'b1, 24'h000000);
        step(2'b01, 1'b0, 1'b0, '0);
        check("R4 history untouched", dco_word, saved);
        step(2'b11, 1'b0, 1'b1, 24'h00FFFF);
        step(2'b11, 1'b1, 1'b0, '0);

        // constrained random phase
        rs = 2'b00; ra = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 50 == 0) begin
                case ($urandom % 6)
                    0, 1, 2: rs = 2'b00;
                    3:       rs = 2'b01;
                    4:       rs = 2'b10;
                    default: rs = 2'b11;
                endcase
            end
            if ($urandom % 40 == 0) ra = ~ra;
            step(rs, ra, 1'(($urandom % 2)), CTR + W'($urandom % 4096) - W'(2048));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule